// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block sits between a requester and a byte-wide SPI master and turns one request into the full byte sequence a serial NOR flash expects. The requests are: read, page program, 4K sector erase, 32K erase, 64K block erase, whole-chip erase, identification read and unique-ID read. The sequencer frames each command with its opcode and a 24-bit address, sent most significant byte first. It sends a write-enable frame before every program or erase. After those commands it polls the status register until the device is idle or a poll budget runs out.

Requests are checked before any byte leaves the block. A request is refused if it has a zero length, targets a block past the last one, runs over a 256-byte page boundary, or asks for a 32K erase at an address that is not aligned to 32K. A refused request finishes at once with an error code. Read data comes out one byte at a time on a strobe. Identification bytes collect in a 64-bit shift register, so the byte received first ends up as the most significant. The byte engine below the sequencer takes one byte together with an end-of-frame flag. It returns one received byte for every byte sent, and it releases chip select after a byte that carries the flag.

Top module: `flash_seq`

## Requirements
- R1: A read (req_op=0) sends opcode 0x03, then the address as three bytes (bits 23:16, 15:8, 7:0), then req_len bytes of 0xFF. Each received byte appears on rd_data with a one-cycle rd_valid strobe. Only the final byte of the frame carries spi_tx_last.
- R2: When cfg_speed is strictly greater than the fast threshold (default 24), a read uses opcode 0x0B and sends one 0xFF dummy byte after the address before data collection starts. At or below the threshold, R1 applies.
- R3: A read or program (req_op=1) with req_len=0 finishes with err_code=1 and sends no SPI byte.
- R4: A program is refused with err_code=2, and no SPI byte is sent, when req_addr[7:0]+req_len exceeds 256. A program that ends exactly at 256 is accepted.
- R5: A program or block-addressed erase (req_op 1..4) with req_addr[23:16] greater than 3 finishes with err_code=3 and sends no SPI byte.
- R6: A 32K erase (req_op=3) with req_addr[14:0] not zero finishes with err_code=4 and sends no SPI byte. An aligned one sends 0x52 and the three address bytes.
- R7: A 4K erase (req_op=2) sends 0x20, then req_addr[23:16], then {req_addr[15:12],4'h0}, then 0x00. A 64K erase (req_op=4) sends 0xD8, req_addr[23:16], 0x00, 0x00. A chip erase (req_op=5) sends 0xC7 alone.
- R8: Every program and erase is preceded by a frame holding only 0x06, which carries spi_tx_last.
- R9: After a program or erase frame, the sequencer waits at least SETTLE_CYC cycles. It then sends status frames (0x05, then 0xFF with spi_tx_last) until a received status byte has bit 0 clear. It then finishes with err_code=0. Only bit 0 of the status byte is examined.
- R10: If cfg_poll_max status reads in a row all show bit 0 set (at least one read is made even when the limit is 0), the operation finishes with err_code=5.
- R11: A unique-ID read (req_op=7) sends 0x4B and four 0x00 bytes, then collects 8 bytes into id_value, first byte received in bits 63:56. An identification read (req_op=6) sends 0x90 and three 0x00 bytes, then collects 2 bytes into id_value[15:0], first byte in bits 15:8.
- R12: spi_tx_data and spi_tx_last hold steady while spi_tx_valid waits for spi_tx_ready. A new byte is offered only after the previous byte's reply arrives. A request is accepted only while req_ready is high, and done pulses for one cycle at the end of each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 3 | Operation code 0..7 (read, program, 4K, 32K, 64K, chip erase, ID, unique ID) |
| req_addr | input | 24 | Byte address |
| req_len | input | LEN_W | Byte count for read and program |
| cfg_speed | input | 8 | Serial clock rate, used to choose fast read |
| cfg_poll_max | input | POLL_W | Limit on busy status reads |
| wr_data | input | 8 | Next program data byte |
| wr_pop | output | 1 | Program byte taken from wr_data this cycle |
| rd_valid | output | 1 | rd_data holds a read byte |
| rd_data | output | 8 | Read data byte |
| id_value | output | 64 | Identification shift register |
| done | output | 1 | One-cycle end-of-request pulse |
| err_code | output | 3 | Result of the finished request (0 ok, 1 length, 2 page, 3 block, 4 align, 5 timeout) |
| spi_tx_valid | output | 1 | Byte offered to the SPI engine |
| spi_tx_ready | input | 1 | SPI engine takes the byte |
| spi_tx_data | output | 8 | Byte to shift out |
| spi_tx_last | output | 1 | Release chip select after this byte |
| spi_rx_valid | input | 1 | Received byte available |
| spi_rx_data | input | 8 | Received byte |

## Verification
The hardest case to reach from the ports is the poll timeout. It needs the flash to report busy on every status read until the budget is spent. The bench's device model answers status frames with busy for a programmable number of reads, and bit 1 of that answer is always set so that only bit 0 can decide the result. The bench sets the busy count far above a small cfg_poll_max and then counts the status frames in its byte log. The settle delay is checked the same way, by stamping each logged byte with its cycle number and measuring the gap between the last command byte and the first status opcode.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    OP_READ = 3'd0, OP_PROG = 3'd1, OP_ER4K = 3'd2, OP_ER32K = 3'd3,
    OP_ER64K = 3'd4, OP_ERCHIP = 3'd5, OP_RDID = 3'd6, OP_UID = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_ZERO_LEN = 3'd1, E_PAGE = 3'd2, E_BLOCK = 3'd3,
    E_ALIGN = 3'd4, E_TIMEOUT = 3'd5
  } err_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WREN, S_HDR, S_DATA, S_WAIT, S_STAT, S_DONE
  } st_e;

  // program and every erase need write-enable and a busy poll
  function automatic logic needs_wren(op_e op);
    return (op != OP_READ) && (op != OP_RDID) && (op != OP_UID);
  endfunction

  // number of bytes in the command header, opcode included
  function automatic logic [2:0] hdr_len(op_e op, logic fast);
    case (op)
      OP_READ:   return fast ? 3'd5 : 3'd4;
      OP_ERCHIP: return 3'd1;
      OP_UID:    return 3'd5;
      default:   return 3'd4;
    endcase
  endfunction

  // header byte at position idx
  function automatic logic [7:0] hdr_byte(op_e op, logic [2:0] idx,
                                          logic [23:0] a, logic [7:0] opc);
    if (idx == 3'd0) return opc;
    case (op)
      OP_ER4K: begin
        if (idx == 3'd1) return a[23:16];
        if (idx == 3'd2) return {a[15:12], 4'h0};
        return 8'h00;
      end
      OP_ER64K:        return (idx == 3'd1) ? a[23:16] : 8'h00;
      OP_RDID, OP_UID: return 8'h00;
      default: begin
        if (idx == 3'd1) return a[23:16];
        if (idx == 3'd2) return a[15:8];
        if (idx == 3'd3) return a[7:0];
        return 8'hFF;
      end
    endcase
  endfunction

endpackage

// File: rtl/flash_seq_check.sv
module flash_seq_check
  import flash_seq_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int MAX_BLOCK = 3
) (
  input  op_e              op,
  input  logic [23:0]      addr,
  input  logic [LEN_W-1:0] len,
  output err_e             err
);
  localparam int SUM_W = LEN_W + 1;
  localparam logic [7:0] MAX_BLK_B = 8'(MAX_BLOCK);

  logic [SUM_W-1:0] page_end;
  logic             is_rw, is_blk;

  assign page_end = SUM_W'(addr[7:0]) + SUM_W'(len);
  assign is_rw    = (op == OP_READ) || (op == OP_PROG);
  assign is_blk   = (op == OP_PROG) || (op == OP_ER4K) ||
                    (op == OP_ER32K) || (op == OP_ER64K);

  always_comb begin
    if (is_rw && len == '0)                         err = E_ZERO_LEN;
    else if (is_blk && addr[23:16] > MAX_BLK_B)     err = E_BLOCK;
    else if (op == OP_PROG && page_end > SUM_W'(256)) err = E_PAGE;
    else if (op == OP_ER32K && addr[14:0] != '0)    err = E_ALIGN;
    else                                            err = E_NONE;
  end
endmodule

// File: rtl/flash_seq_xfer.sv
module flash_seq_xfer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] byte_i,
  input  logic       last_i,
  output logic       idle,
  output logic       fin,
  output logic [7:0] rx,
  output logic       spi_tx_valid,
  input  logic       spi_tx_ready,
  output logic [7:0] spi_tx_data,
  output logic       spi_tx_last,
  input  logic       spi_rx_valid,
  input  logic [7:0] spi_rx_data
);
  typedef enum logic [1:0] {X_IDLE, X_SEND, X_WAIT} xst_e;
  xst_e       st;
  logic [7:0] byte_q;
  logic       last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= X_IDLE;
      byte_q <= '0;
      last_q <= 1'b0;
    end else begin
      case (st)
        X_IDLE: if (start) begin
          byte_q <= byte_i;
          last_q <= last_i;
          st     <= X_SEND;
        end
        X_SEND:  if (spi_tx_ready) st <= X_WAIT;
        X_WAIT:  if (spi_rx_valid) st <= X_IDLE;
        default: st <= X_IDLE;
      endcase
    end
  end

  assign idle         = (st == X_IDLE);
  assign fin          = (st == X_WAIT) && spi_rx_valid;
  assign rx           = spi_rx_data;
  assign spi_tx_valid = (st == X_SEND);
  assign spi_tx_data  = byte_q;
  assign spi_tx_last  = last_q;

  // R12: an offered byte stays put until the engine takes it
  a_r12_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_tx_valid && !spi_tx_ready) |=>
      (spi_tx_valid && $stable(spi_tx_data) && $stable(spi_tx_last)));

  // R12: no byte is offered while a reply is still owed
  a_r12_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_tx_valid && spi_tx_ready) |=> !spi_tx_valid);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int LEN_W        = 16,
  parameter int POLL_W       = 16,
  parameter int SETTLE_CYC   = 16,
  parameter int MAX_BLOCK    = 3,
  parameter int FAST_MIN_MHZ = 24,
  parameter logic [7:0] OPC_READ   = 8'h03,
  parameter logic [7:0] OPC_FREAD  = 8'h0B,
  parameter logic [7:0] OPC_PROG   = 8'h02,
  parameter logic [7:0] OPC_WREN   = 8'h06,
  parameter logic [7:0] OPC_STAT   = 8'h05,
  parameter logic [7:0] OPC_ER4K   = 8'h20,
  parameter logic [7:0] OPC_ER32K  = 8'h52,
  parameter logic [7:0] OPC_ER64K  = 8'hD8,
  parameter logic [7:0] OPC_ERCHIP = 8'hC7,
  parameter logic [7:0] OPC_RDID   = 8'h90,
  parameter logic [7:0] OPC_UID    = 8'h4B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [23:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        cfg_speed,
  input  logic [POLL_W-1:0] cfg_poll_max,
  input  logic [7:0]        wr_data,
  output logic              wr_pop,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [63:0]       id_value,
  output logic              done,
  output logic [2:0]        err_code,
  output logic              spi_tx_valid,
  input  logic              spi_tx_ready,
  output logic [7:0]        spi_tx_data,
  output logic              spi_tx_last,
  input  logic              spi_rx_valid,
  input  logic [7:0]        spi_rx_data
);
  localparam int WCNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [7:0] FAST_MIN_B = 8'(FAST_MIN_MHZ);

  st_e               state;
  op_e               op_in, op_q;
  err_e              chk_err, err_q;
  logic [23:0]       addr_q;
  logic              fast_q, fast_now, pend;
  logic [2:0]        hlen_q, hidx;
  logic [LEN_W-1:0]  dlen_q, didx, dlen_in;
  logic [WCNT_W-1:0] wcnt;
  logic [POLL_W-1:0] pcnt;
  logic [63:0]       id_q;
  logic [7:0]        opc, x_byte, x_rx;
  logic              x_last, x_start, x_idle, x_fin;
  logic              hdr_end, data_end, poll_spent, reject;
  st_e               post_st;

  assign op_in    = op_e'(req_op);
  assign fast_now = cfg_speed > FAST_MIN_B;

  always_comb begin
    case (op_in)
      OP_READ, OP_PROG: dlen_in = req_len;
      OP_RDID:          dlen_in = LEN_W'(2);
      OP_UID:           dlen_in = LEN_W'(8);
      default:          dlen_in = '0;
    endcase
  end

  flash_seq_check #(.LEN_W(LEN_W), .MAX_BLOCK(MAX_BLOCK)) u_check (
    .op(op_in), .addr(req_addr), .len(req_len), .err(chk_err)
  );

  always_comb begin
    case (op_q)
      OP_READ:   opc = fast_q ? OPC_FREAD : OPC_READ;
      OP_PROG:   opc = OPC_PROG;
      OP_ER4K:   opc = OPC_ER4K;
      OP_ER32K:  opc = OPC_ER32K;
      OP_ER64K:  opc = OPC_ER64K;
      OP_ERCHIP: opc = OPC_ERCHIP;
      OP_RDID:   opc = OPC_RDID;
      default:   opc = OPC_UID;
    endcase
  end

  // named events used by the FSM and the assertions
  assign hdr_end    = (hidx == hlen_q - 3'd1);
  assign data_end   = (didx == dlen_q - LEN_W'(1));
  assign poll_spent = ({1'b0, pcnt} + 1'b1) >= {1'b0, cfg_poll_max};
  assign post_st    = needs_wren(op_q) ? S_WAIT : S_DONE;
  assign reject     = (state == S_IDLE) && req_valid && (chk_err != E_NONE);
  assign x_start    = pend && x_idle;

  // byte offered for the current step
  always_comb begin
    x_byte = 8'hFF;
    x_last = 1'b0;
    case (state)
      S_WREN: begin x_byte = OPC_WREN; x_last = 1'b1; end
      S_HDR: begin
        x_byte = hdr_byte(op_q, hidx, addr_q, opc);
        x_last = hdr_end && (dlen_q == '0);
      end
      S_DATA: begin
        x_byte = (op_q == OP_PROG) ? wr_data : 8'hFF;
        x_last = data_end;
      end
      S_STAT: begin
        x_byte = (hidx == 3'd0) ? OPC_STAT : 8'hFF;
        x_last = (hidx != 3'd0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; op_q <= OP_READ; err_q <= E_NONE; addr_q <= '0;
      fast_q <= 1'b0; pend <= 1'b0; hlen_q <= 3'd1; hidx <= '0;
      dlen_q <= '0; didx <= '0; wcnt <= '0; pcnt <= '0; id_q <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (x_start) pend <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op_q   <= op_in;
          addr_q <= req_addr;
          fast_q <= fast_now && (op_in == OP_READ);
          hlen_q <= hdr_len(op_in, fast_now);
          dlen_q <= dlen_in;
          hidx <= '0; didx <= '0; wcnt <= '0; pcnt <= '0;
          err_q  <= chk_err;
          if (chk_err != E_NONE) state <= S_DONE;
          else begin
            pend  <= 1'b1;
            state <= needs_wren(op_in) ? S_WREN : S_HDR;
          end
        end
        S_WREN: if (x_fin) begin state <= S_HDR; pend <= 1'b1; end
        S_HDR: if (x_fin) begin
          if (!hdr_end) begin hidx <= hidx + 3'd1; pend <= 1'b1; end
          else if (dlen_q != '0) begin state <= S_DATA; pend <= 1'b1; end
          else state <= post_st;
        end
        S_DATA: if (x_fin) begin
          if (op_q == OP_READ) begin rd_valid <= 1'b1; rd_data <= x_rx; end
          if (op_q == OP_RDID || op_q == OP_UID) id_q <= {id_q[55:0], x_rx};
          if (data_end) state <= post_st;
          else begin didx <= didx + LEN_W'(1); pend <= 1'b1; end
        end
        S_WAIT: begin
          if (wcnt == WCNT_W'(SETTLE_CYC - 1)) begin
            state <= S_STAT; hidx <= '0; pend <= 1'b1;
          end else wcnt <= wcnt + WCNT_W'(1);
        end
        S_STAT: if (x_fin) begin
          if (hidx == 3'd0) begin hidx <= 3'd1; pend <= 1'b1; end
          else if (!x_rx[0]) state <= S_DONE;
          else if (poll_spent) begin err_q <= E_TIMEOUT; state <= S_DONE; end
          else begin pcnt <= pcnt + POLL_W'(1); hidx <= '0; pend <= 1'b1; end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  flash_seq_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .start(x_start), .byte_i(x_byte), .last_i(x_last),
    .idle(x_idle), .fin(x_fin), .rx(x_rx),
    .spi_tx_valid(spi_tx_valid), .spi_tx_ready(spi_tx_ready),
    .spi_tx_data(spi_tx_data), .spi_tx_last(spi_tx_last),
    .spi_rx_valid(spi_rx_valid), .spi_rx_data(spi_rx_data)
  );

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign err_code  = err_q;
  assign id_value  = id_q;
  assign wr_pop    = x_start && (state == S_DATA) && (op_q == OP_PROG);

  // R3 R4 R5 R6: a refused request ends next cycle with no byte offered
  a_r3_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (done && !spi_tx_valid));

  // R8: write-enable is a frame of its own
  a_r8_wren_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_tx_valid && state == S_WREN) |-> (spi_tx_last && spi_tx_data == OPC_WREN));

  // R9: status frame is opcode then a closing fill byte
  a_r9_stat_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_tx_valid && state == S_STAT) |-> (spi_tx_last == (hidx != 3'd0)));

  // R1: read strobes only come from read requests
  a_r1_rd_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (op_q == OP_READ));

  // R12: done lasts exactly one cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/flash_seq_test.sv
module flash_seq_test;
  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [7:0]  cfg_speed = 8'd10;
  logic [15:0] cfg_poll_max = 16'd1000;
  logic [7:0]  wr_data;
  logic        wr_pop, rd_valid, done;
  logic [7:0]  rd_data;
  logic [63:0] id_value;
  logic [2:0]  err_code;
  logic        spi_tx_valid, spi_tx_ready, spi_tx_last;
  logic [7:0]  spi_tx_data;
  logic        spi_rx_valid = 1'b0;
  logic [7:0]  spi_rx_data = '0;

  flash_seq #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .cfg_speed(cfg_speed), .cfg_poll_max(cfg_poll_max),
    .wr_data(wr_data), .wr_pop(wr_pop), .rd_valid(rd_valid), .rd_data(rd_data),
    .id_value(id_value), .done(done), .err_code(err_code),
    .spi_tx_valid(spi_tx_valid), .spi_tx_ready(spi_tx_ready),
    .spi_tx_data(spi_tx_data), .spi_tx_last(spi_tx_last),
    .spi_rx_valid(spi_rx_valid), .spi_rx_data(spi_rx_data)
  );

  // ---- flash device model and byte log ----
  logic [7:0] log_d [512];
  logic       log_l [512];
  int         log_t [512];
  int nlog = 0, fidx = 0, cyc = 0, polls = 0, poll_base = 0, busy_goal = 0;
  logic [7:0] fop = '0;
  logic gate = 1'b0, inflight = 1'b0;
  int popcnt = 0, pop_base = 0;
  logic [7:0] rdbuf [64];
  int nrd = 0;

  assign spi_tx_ready = spi_tx_valid && gate && !inflight;
  assign wr_data = 8'hC0 + 8'(popcnt - pop_base);

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    gate <= ~gate;
    if (wr_pop) popcnt <= popcnt + 1;
    if (spi_rx_valid) begin spi_rx_valid <= 1'b0; inflight <= 1'b0; end
    if (spi_tx_valid && spi_tx_ready) begin
      log_d[nlog] <= spi_tx_data;
      log_l[nlog] <= spi_tx_last;
      log_t[nlog] <= cyc;
      nlog <= nlog + 1;
      inflight <= 1'b1;
      spi_rx_valid <= 1'b1;
      if (fidx == 0) fop <= spi_tx_data;
      if (fidx == 1 && fop == 8'h05) begin
        spi_rx_data <= ((polls - poll_base) < busy_goal) ? 8'h03 : 8'h02;
        polls <= polls + 1;
      end else spi_rx_data <= 8'(fidx) ^ 8'h3C;
      fidx <= spi_tx_last ? 0 : fidx + 1;
    end
  end

  always @(negedge clk) if (rd_valid) begin rdbuf[nrd] = rd_data; nrd = nrd + 1; end

  // ---- checking ----
  int nchk = 0, nfail = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_byte(input string req, input int i, input logic [7:0] v,
                          input logic l);
    chk(req, $sformatf("byte[%0d]", i), {56'd0, log_d[i]}, {56'd0, v});
    chk(req, $sformatf("last[%0d]", i), {63'd0, log_l[i]}, {63'd0, l});
  endtask

  task automatic run(input logic [2:0] op, input logic [23:0] a,
                     input logic [15:0] len, output logic [2:0] err);
    int w;
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R12 watchdog actual=0 expected=1 (done)");
    end
    err = err_code;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12", "req_ready at reset", {63'd0, req_ready}, 64'd1);
    chk("R12", "done at reset", {63'd0, done}, 64'd0);
    chk("R12", "tx_valid at reset", {63'd0, spi_tx_valid}, 64'd0);
  endtask

  task automatic t_read_slow();
    logic [2:0] e; int b = nlog, r = nrd;
    cfg_speed = 8'd24;
    run(3'd0, 24'h012345, 16'd3, e);
    chk("R1", "err", {61'd0, e}, 64'd0);
    chk("R1", "frame length", 64'(nlog - b), 64'd7);
    chk_byte("R1", b, 8'h03, 1'b0); chk_byte("R1", b+1, 8'h01, 1'b0);
    chk_byte("R1", b+2, 8'h23, 1'b0); chk_byte("R1", b+3, 8'h45, 1'b0);
    chk_byte("R1", b+4, 8'hFF, 1'b0); chk_byte("R1", b+5, 8'hFF, 1'b0);
    chk_byte("R1", b+6, 8'hFF, 1'b1);
    chk("R1", "rd count", 64'(nrd - r), 64'd3);
    for (int k = 0; k < 3; k++)
      chk("R1", "rd byte", {56'd0, rdbuf[r+k]}, {56'd0, 8'(4 + k) ^ 8'h3C});
  endtask

  task automatic t_read_fast();
    logic [2:0] e; int b = nlog, r = nrd;
    cfg_speed = 8'd40;
    run(3'd0, 24'h012345, 16'd2, e);
    chk("R2", "frame length", 64'(nlog - b), 64'd7);
    chk_byte("R2", b, 8'h0B, 1'b0); chk_byte("R2", b+3, 8'h45, 1'b0);
    chk_byte("R2", b+4, 8'hFF, 1'b0); chk_byte("R2", b+6, 8'hFF, 1'b1);
    chk("R2", "rd count", 64'(nrd - r), 64'd2);
    chk("R2", "rd first", {56'd0, rdbuf[r]}, {56'd0, 8'd5 ^ 8'h3C});
    chk("R2", "rd second", {56'd0, rdbuf[r+1]}, {56'd0, 8'd6 ^ 8'h3C});
    cfg_speed = 8'd10;
  endtask

  task automatic t_rejects();
    logic [2:0] e; int b = nlog;
    run(3'd0, 24'h000010, 16'd0, e); chk("R3", "read len0 err", {61'd0, e}, 64'd1);
    run(3'd1, 24'h000010, 16'd0, e); chk("R3", "prog len0 err", {61'd0, e}, 64'd1);
    run(3'd1, 24'h0100F0, 16'd17, e); chk("R4", "page cross err", {61'd0, e}, 64'd2);
    run(3'd4, 24'h040000, 16'd0, e); chk("R5", "block err", {61'd0, e}, 64'd3);
    run(3'd1, 24'h050000, 16'd1, e); chk("R5", "prog block err", {61'd0, e}, 64'd3);
    run(3'd3, 24'h014000, 16'd0, e); chk("R6", "align err", {61'd0, e}, 64'd4);
    chk("R3", "no spi bytes on rejects", 64'(nlog - b), 64'd0);
  endtask

  task automatic t_prog();
    logic [2:0] e; int b = nlog;
    pop_base = popcnt; poll_base = polls; busy_goal = 2;
    run(3'd1, 24'h0100F0, 16'd16, e);
    chk("R4", "page end at 256 accepted", {61'd0, e}, 64'd0);
    chk("R9", "frame length", 64'(nlog - b), 64'd27);
    chk_byte("R8", b, 8'h06, 1'b1);
    chk_byte("R4", b+1, 8'h02, 1'b0); chk_byte("R4", b+2, 8'h01, 1'b0);
    chk_byte("R4", b+3, 8'h00, 1'b0); chk_byte("R4", b+4, 8'hF0, 1'b0);
    for (int k = 0; k < 16; k++)
      chk_byte("R4", b+5+k, 8'hC0 + 8'(k), k == 15);
    for (int k = 0; k < 3; k++) begin
      chk_byte("R9", b+21+2*k, 8'h05, 1'b0);
      chk_byte("R9", b+22+2*k, 8'hFF, 1'b1);
    end
    chk("R9", "settle gap ok", {63'd0, (log_t[b+21] - log_t[b+20]) > SETTLE}, 64'd1);
  endtask

  task automatic t_erases();
    logic [2:0] e; int b;
    busy_goal = 0;
    b = nlog; poll_base = polls;
    run(3'd2, 24'h02A123, 16'd0, e);
    chk("R7", "4k err", {61'd0, e}, 64'd0);
    chk_byte("R8", b, 8'h06, 1'b1);
    chk_byte("R7", b+1, 8'h20, 1'b0); chk_byte("R7", b+2, 8'h02, 1'b0);
    chk_byte("R7", b+3, 8'hA0, 1'b0); chk_byte("R7", b+4, 8'h00, 1'b1);
    chk("R9", "4k total", 64'(nlog - b), 64'd7);
    b = nlog;
    run(3'd3, 24'h018000, 16'd0, e);
    chk("R6", "32k aligned err", {61'd0, e}, 64'd0);
    chk_byte("R6", b+1, 8'h52, 1'b0); chk_byte("R6", b+2, 8'h01, 1'b0);
    chk_byte("R6", b+3, 8'h80, 1'b0); chk_byte("R6", b+4, 8'h00, 1'b1);
    b = nlog;
    run(3'd4, 24'h03ABCD, 16'd0, e);
    chk_byte("R7", b+1, 8'hD8, 1'b0); chk_byte("R7", b+2, 8'h03, 1'b0);
    chk_byte("R7", b+3, 8'h00, 1'b0); chk_byte("R7", b+4, 8'h00, 1'b1);
    b = nlog;
    run(3'd5, 24'h000000, 16'd0, e);
    chk("R7", "chip erase total", 64'(nlog - b), 64'd4);
    chk_byte("R8", b, 8'h06, 1'b1); chk_byte("R7", b+1, 8'hC7, 1'b1);
  endtask

  task automatic t_timeout();
    logic [2:0] e; int b = nlog;
    busy_goal = 100; poll_base = polls; cfg_poll_max = 16'd4;
    run(3'd4, 24'h010000, 16'd0, e);
    chk("R10", "timeout err", {61'd0, e}, 64'd5);
    chk("R10", "status reads", 64'(nlog - b), 64'd5 + 64'd8);
    chk_byte("R10", nlog - 2, 8'h05, 1'b0);
    busy_goal = 0; cfg_poll_max = 16'd1000;
  endtask

  task automatic t_ids();
    logic [2:0] e; int b = nlog; logic [63:0] exp = '0;
    run(3'd7, 24'hFFFFFF, 16'd0, e);
    chk("R11", "uid frame length", 64'(nlog - b), 64'd13);
    chk_byte("R11", b, 8'h4B, 1'b0); chk_byte("R11", b+4, 8'h00, 1'b0);
    chk_byte("R11", b+12, 8'hFF, 1'b1);
    for (int k = 5; k < 13; k++) exp = {exp[55:0], 8'(k) ^ 8'h3C};
    chk("R11", "uid value", id_value, exp);
    b = nlog;
    run(3'd6, 24'h000000, 16'd0, e);
    chk("R11", "rdid frame length", 64'(nlog - b), 64'd6);
    chk_byte("R11", b, 8'h90, 1'b0); chk_byte("R11", b+5, 8'hFF, 1'b1);
    chk("R11", "rdid value", {48'd0, id_value[15:0]}, {48'd0, 8'h38, 8'h39});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_read_slow();
    t_read_fast();
    t_rejects();
    t_prog();
    t_erases();
    t_timeout();
    t_ids();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule